// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the offset and the linear address of a memory operand for a processor with segmented memory that runs both a narrow (16-bit) and a wide (32-bit) addressing form. One request carries an addressing mode, two register values (a base candidate and an index candidate), a register select, a scale code, a displacement with its size code, the base of the segment, and the two controls that decide the address width: the descriptor default bit and the per-instruction address-size prefix flag.

The block adds the terms that the mode calls for, scales the index when the wide form is active, and wraps the sum at the active width. It then adds the segment base to form the linear address. It also reports which segment the operand defaults to, and an explicit segment override takes precedence over that default. All results are registered. They appear one clock after the request, marked by an output valid flag. Limit checks, paging and instruction fetch are left to other blocks.

Top module: `seg_addr_gen`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, the data outputs keep their last values.
- R2: The wide form is active (`addr32` = 1) when `def32` XOR `asize_pfx` is 1. Otherwise the narrow form is active.
- R3: Mode codes are as follows. 0 (direct) adds the displacement only. 1 (register indirect) adds one register and no displacement: `reg_sel` 0 (BX) or 1 (BP) takes `base_val`, and 2 (SI) or 3 (DI) takes `index_val`. 2 (based) adds `base_val` and the displacement. 3 (indexed) adds the index and the displacement. 4 (based-indexed) adds all three. Codes 5 to 7 act as direct.
- R4: `disp_sz` 0 sign-extends `disp[7:0]`. `disp_sz` 1 sign-extends `disp[15:0]`. `disp_sz` 2 or 3 uses all 32 bits.
- R5: In the narrow form the scale code is ignored and the effective address wraps modulo 2^16. Bits 31:16 of `ea` are then 0.
- R6: In the wide form the index of modes 3 and 4 is shifted left by `scale` (0 to 3, for ×1, ×2, ×4, ×8), and the effective address wraps modulo 2^32. The register indirect mode never scales.
- R7: `lin_addr` equals `seg_base` + `ea`, modulo 2^32.
- R8: With no override, `seg_sel` is 2 (stack segment) for a narrow-form operand whose base is BP, and 3 (data segment) otherwise. A BP base means mode 1 with `reg_sel` 1, or mode 2 or 4 with `reg_sel[0]` 1. In the wide form the default is always 3.
- R9: When `seg_ovr_en` is 1, `seg_sel` equals `seg_ovr`, whatever the default would have been.
- R10: After reset, `out_valid`, `ea`, `lin_addr`, `addr32` and `seg_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| reg_sel | input | 2 | Register select: BX, BP, SI or DI |
| base_val | input | 32 | Value of the base register |
| index_val | input | 32 | Value of the index register |
| scale | input | 2 | Index shift amount (wide form only) |
| disp | input | 32 | Displacement |
| disp_sz | input | 2 | Displacement size code |
| seg_base | input | 32 | Base of the segment in use |
| def32 | input | 1 | Descriptor default width bit |
| asize_pfx | input | 1 | Address-size prefix present |
| seg_ovr_en | input | 1 | Segment override present |
| seg_ovr | input | 3 | Override segment code |
| out_valid | output | 1 | Results valid |
| ea | output | 32 | Effective address |
| lin_addr | output | 32 | Linear address |
| addr32 | output | 1 | Wide form was active |
| seg_sel | output | 3 | Segment code for the operand |

## Verification
The embedded assertions check the following on every cycle: the one-cycle valid timing, the holding of the outputs when no request arrives, the zero upper half of a narrow effective address, the width decision, the override precedence, and the relation between the linear address and the segment base. The term selection per mode, the displacement extension, the index scaling and the BP-to-stack-segment default depend on the arithmetic for a given request. Only the directed scenarios show these, by comparing against values the bench computes. The same applies to wrap-around at both widths and to the unused mode codes.

// File: rtl/seg_addr_pkg.sv
// Shared constants for the segmented address generator.
// Assumes: 3-bit mode codes and 3-bit segment codes as listed in the brief.
package seg_addr_pkg;
    localparam logic [2:0] AM_DIRECT   = 3'd0;
    localparam logic [2:0] AM_INDIRECT = 3'd1;
    localparam logic [2:0] AM_BASED    = 3'd2;
    localparam logic [2:0] AM_INDEXED  = 3'd3;
    localparam logic [2:0] AM_BIDX     = 3'd4;

    localparam logic [2:0] SEG_STACK = 3'd2;
    localparam logic [2:0] SEG_DATA  = 3'd3;

    localparam logic [1:0] DSZ_BYTE = 2'd0;
    localparam logic [1:0] DSZ_WORD = 2'd1;

    // Which terms a mode contributes
    typedef struct packed {
        logic use_base;
        logic use_index;
        logic use_disp;
        logic scaled;
    } terms_t;
endpackage

// File: rtl/sag_size_ctl.sv
// Address-width and default-segment decision.
// Assumes: bp_form is already decoded from mode/reg_sel; the override wins.
module sag_size_ctl
    import seg_addr_pkg::*;
(
    input  logic       def32,
    input  logic       asize_pfx,
    input  logic       bp_form,
    input  logic       seg_ovr_en,
    input  logic [2:0] seg_ovr,
    output logic       addr32,
    output logic [2:0] seg_sel
);
    // Width: the prefix toggles the descriptor default
    always_comb addr32 = def32 ^ asize_pfx;

    // Segment: override first, then the BP-based narrow default
    always_comb begin
        if (seg_ovr_en)
            seg_sel = seg_ovr;
        else if (bp_form && !addr32)
            seg_sel = SEG_STACK;
        else
            seg_sel = SEG_DATA;
    end
endmodule

// File: rtl/sag_term_sel.sv
// Selects and conditions the base, index and displacement terms of one
// request. It extends the displacement and scales the index in the wide form.
// Assumes: AW >= 16; wrapping at the narrow width is done downstream.
module sag_term_sel
    import seg_addr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SCALE_W = 2
) (
    input  logic [2:0]         mode,
    input  logic [1:0]         reg_sel,
    input  logic               addr32,
    input  logic [AW-1:0]      base_val,
    input  logic [AW-1:0]      index_val,
    input  logic [SCALE_W-1:0] scale,
    input  logic [AW-1:0]      disp,
    input  logic [1:0]         disp_sz,
    output logic [AW-1:0]      term_base,
    output logic [AW-1:0]      term_index,
    output logic [AW-1:0]      term_disp,
    output logic               bp_form
);
    terms_t               t;
    logic [AW-1:0]        disp_ext;
    logic [SCALE_W-1:0]   shamt;

    // Mode decode into term enables
    always_comb begin
        t = '{use_base: 1'b0, use_index: 1'b0, use_disp: 1'b1, scaled: 1'b0};
        unique case (mode)
            AM_INDIRECT: begin
                t.use_disp  = 1'b0;
                t.use_base  = ~reg_sel[1];
                t.use_index = reg_sel[1];
            end
            AM_BASED:   t.use_base = 1'b1;
            AM_INDEXED: begin
                t.use_index = 1'b1;
                t.scaled    = 1'b1;
            end
            AM_BIDX: begin
                t.use_base  = 1'b1;
                t.use_index = 1'b1;
                t.scaled    = 1'b1;
            end
            default: ;
        endcase
    end

    // BP-based form flag for the default-segment choice
    always_comb begin
        bp_form = ((mode == AM_INDIRECT) && (reg_sel == 2'd1)) ||
                  (((mode == AM_BASED) || (mode == AM_BIDX)) && reg_sel[0]);
    end

    // Displacement sign extension by size code
    always_comb begin
        unique case (disp_sz)
            DSZ_BYTE: disp_ext = {{(AW-8){disp[7]}}, disp[7:0]};
            DSZ_WORD: disp_ext = {{(AW-16){disp[15]}}, disp[15:0]};
            default:  disp_ext = disp;
        endcase
    end

    // Shift amount: only in the wide form, only for scaled modes
    always_comb shamt = (addr32 && t.scaled) ? scale : '0;

    // Gate each term by its enable
    always_comb begin
        term_base  = t.use_base  ? base_val             : '0;
        term_index = t.use_index ? (index_val << shamt) : '0;
        term_disp  = t.use_disp  ? disp_ext             : '0;
    end
endmodule

// File: rtl/sag_sum.sv
// Three-term adder with wrap at the active width, and the segment-base add.
// Assumes: NW <= AW; the linear address wraps at AW bits.
module sag_sum #(
    parameter int AW = 32,
    parameter int NW = 16
) (
    input  logic [AW-1:0] term_base,
    input  logic [AW-1:0] term_index,
    input  logic [AW-1:0] term_disp,
    input  logic          addr32,
    input  logic [AW-1:0] seg_base,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] lin
);
    logic [AW-1:0] sum;

    // Raw offset sum at full width
    always_comb sum = term_base + term_index + term_disp;

    // Narrow-form wrap: keep only the low NW bits
    generate
        if (NW < AW) begin : g_narrow
            always_comb ea = addr32 ? sum : {{(AW-NW){1'b0}}, sum[NW-1:0]};
        end else begin : g_full
            always_comb ea = sum;
        end
    endgenerate

    // Linear address
    always_comb lin = seg_base + ea;
endmodule

// File: rtl/seg_addr_gen.sv
// Top: registered effective/linear address generator with a one-cycle latency.
// Assumes: one request per valid cycle; the outputs hold between requests.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NW      = 16,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         mode,
    input  logic [1:0]         reg_sel,
    input  logic [AW-1:0]      base_val,
    input  logic [AW-1:0]      index_val,
    input  logic [SCALE_W-1:0] scale,
    input  logic [AW-1:0]      disp,
    input  logic [1:0]         disp_sz,
    input  logic [AW-1:0]      seg_base,
    input  logic               def32,
    input  logic               asize_pfx,
    input  logic               seg_ovr_en,
    input  logic [2:0]         seg_ovr,
    output logic               out_valid,
    output logic [AW-1:0]      ea,
    output logic [AW-1:0]      lin_addr,
    output logic               addr32,
    output logic [2:0]         seg_sel
);
    logic          w32;
    logic          bp_form;
    logic [2:0]    seg_d;
    logic [AW-1:0] tb, ti, td, ea_d, lin_d;

    sag_size_ctl u_size (
        .def32(def32), .asize_pfx(asize_pfx), .bp_form(bp_form),
        .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr),
        .addr32(w32), .seg_sel(seg_d)
    );

    sag_term_sel #(.AW(AW), .SCALE_W(SCALE_W)) u_terms (
        .mode(mode), .reg_sel(reg_sel), .addr32(w32),
        .base_val(base_val), .index_val(index_val), .scale(scale),
        .disp(disp), .disp_sz(disp_sz),
        .term_base(tb), .term_index(ti), .term_disp(td), .bp_form(bp_form)
    );

    sag_sum #(.AW(AW), .NW(NW)) u_sum (
        .term_base(tb), .term_index(ti), .term_disp(td),
        .addr32(w32), .seg_base(seg_base), .ea(ea_d), .lin(lin_d)
    );

    // Valid pipeline stage
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers, loaded only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea       <= '0;
            lin_addr <= '0;
            addr32   <= 1'b0;
            seg_sel  <= '0;
        end else if (in_valid) begin
            ea       <= ea_d;
            lin_addr <= lin_d;
            addr32   <= w32;
            seg_sel  <= seg_d;
        end
    end

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> ($stable(ea) && $stable(lin_addr) && $stable(seg_sel)));

    // R2
    width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (def32 == asize_pfx)) |=> !addr32);

    // R5
    narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !addr32) |-> (ea[AW-1:NW] == '0));

    // R7
    linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid) |=> (lin_addr == $past(seg_base) + ea));

    // R9
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seg_ovr_en) |=> (seg_sel == $past(seg_ovr)));
endmodule

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] base_val = '0, index_val = '0, disp = '0, seg_base = '0;
    logic [1:0]  scale = '0, disp_sz = '0;
    logic        def32 = 1'b0, asize_pfx = 1'b0, seg_ovr_en = 1'b0;
    logic [2:0]  seg_ovr = '0;
    logic        out_valid, addr32;
    logic [31:0] ea, lin_addr;
    logic [2:0]  seg_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .reg_sel(reg_sel), .base_val(base_val), .index_val(index_val),
        .scale(scale), .disp(disp), .disp_sz(disp_sz), .seg_base(seg_base),
        .def32(def32), .asize_pfx(asize_pfx), .seg_ovr_en(seg_ovr_en),
        .seg_ovr(seg_ovr), .out_valid(out_valid), .ea(ea),
        .lin_addr(lin_addr), .addr32(addr32), .seg_sel(seg_sel)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Spec-level model of the effective address
    function automatic logic [31:0] model_ea(logic [2:0] m, logic [1:0] rs, logic w,
        logic [31:0] bv, logic [31:0] iv, logic [1:0] sc, logic [31:0] d, logic [1:0] ds);
        logic [31:0] dx, isc, s;
        dx  = (ds == 0) ? {{24{d[7]}}, d[7:0]} : (ds == 1) ? {{16{d[15]}}, d[15:0]} : d;
        isc = w ? (iv << sc) : iv;
        case (m)
            3'd1:    s = rs[1] ? iv : bv;
            3'd2:    s = bv + dx;
            3'd3:    s = isc + dx;
            3'd4:    s = bv + isc + dx;
            default: s = dx;
        endcase
        return w ? s : {16'h0, s[15:0]};
    endfunction

    function automatic logic [2:0] model_seg(logic [2:0] m, logic [1:0] rs, logic w,
        logic oe, logic [2:0] o);
        logic bp;
        bp = (m == 3'd1 && rs == 2'd1) || ((m == 3'd2 || m == 3'd4) && rs[0]);
        if (oe) return o;
        return (bp && !w) ? 3'd2 : 3'd3;
    endfunction

    // Drive one request at negedge, check all results one clock later
    task automatic apply(string req, logic [2:0] m, logic [1:0] rs, logic [31:0] bv,
        logic [31:0] iv, logic [1:0] sc, logic [31:0] d, logic [1:0] ds,
        logic [31:0] sb, logic d32, logic pf, logic oe, logic [2:0] o);
        logic        w;
        logic [31:0] e;
        w = d32 ^ pf;
        e = model_ea(m, rs, w, bv, iv, sc, d, ds);
        @(negedge clk);
        in_valid = 1'b1; mode = m; reg_sel = rs; base_val = bv; index_val = iv;
        scale = sc; disp = d; disp_sz = ds; seg_base = sb; def32 = d32;
        asize_pfx = pf; seg_ovr_en = oe; seg_ovr = o;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", {31'h0, out_valid}, 32'h1);
        check(req, "ea", ea, e);
        check(req, "lin_addr", lin_addr, sb + e);
        check(req, "addr32", {31'h0, addr32}, {31'h0, w});
        check(req, "seg_sel", {29'h0, seg_sel}, {29'h0, model_seg(m, rs, w, oe, o)});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10", "out_valid", {31'h0, out_valid}, 32'h0);
        check("R10", "ea", ea, 32'h0);
        check("R10", "lin_addr", lin_addr, 32'h0);
        check("R10", "seg_sel", {29'h0, seg_sel}, 32'h0);
    endtask

    task automatic t_direct();
        apply("R3", 3'd0, 2'd0, 32'h5555, 32'h6666, 2'd0, 32'h1234, 2'd1,
              32'h0001_0000, 0, 0, 0, 3'd0);
        check("R3", "direct ea", ea, 32'h1234);
        // R3: unused mode codes act as direct
        apply("R3", 3'd6, 2'd1, 32'h5555, 32'h6666, 2'd0, 32'h0042, 2'd0,
              32'h0, 0, 0, 0, 3'd0);
        check("R3", "mode6 ea", ea, 32'h0042);
    endtask

    task automatic t_indirect();
        apply("R3", 3'd1, 2'd2, 32'h1111, 32'hABCD, 2'd3, 32'h0099, 2'd0,
              32'h0, 0, 0, 0, 3'd0);
        check("R3", "SI indirect", ea, 32'hABCD);
        apply("R8", 3'd1, 2'd1, 32'h2468, 32'hABCD, 2'd0, 32'h0099, 2'd0,
              32'h0, 0, 0, 0, 3'd0);
        check("R8", "BP indirect seg", {29'h0, seg_sel}, 32'h2);
        // R6: indirect in wide form never scales
        apply("R6", 3'd1, 2'd3, 32'h0, 32'h0000_0100, 2'd3, 32'h0, 2'd2,
              32'h0, 1, 0, 0, 3'd0);
        check("R6", "DI indirect no scale", ea, 32'h0000_0100);
    endtask

    task automatic t_based_indexed();
        // R4: byte displacement 0xF0 = -16
        apply("R4", 3'd2, 2'd1, 32'h1000, 32'h0, 2'd0, 32'h0000_00F0, 2'd0,
              32'h0002_0000, 0, 0, 0, 3'd0);
        check("R4", "based disp8 neg", ea, 32'h0FF0);
        check("R8", "based BP seg", {29'h0, seg_sel}, 32'h2);
        // R5: scale ignored in narrow form
        apply("R5", 3'd3, 2'd2, 32'h0, 32'h0010, 2'd3, 32'h2000, 2'd1,
              32'h0, 0, 0, 0, 3'd0);
        check("R5", "indexed no scale", ea, 32'h2010);
    endtask

    task automatic t_wrap16();
        apply("R5", 3'd4, 2'd0, 32'h1234_FFF0, 32'h0000_0020, 2'd0, 32'h0, 2'd0,
              32'h0, 0, 0, 0, 3'd0);
        check("R5", "bidx wrap16", ea, 32'h0010);
    endtask

    task automatic t_wide();
        apply("R6", 3'd4, 2'd1, 32'h1000_0000, 32'h0000_0100, 2'd2, 32'h0000_0004, 2'd2,
              32'h0, 1, 0, 0, 3'd0);
        check("R6", "bidx scale4", ea, 32'h1000_0404);
        check("R8", "wide BP seg", {29'h0, seg_sel}, 32'h3);
        apply("R6", 3'd2, 2'd0, 32'hFFFF_FFF0, 32'h0, 2'd0, 32'h0000_0020, 2'd2,
              32'h0, 1, 0, 0, 3'd0);
        check("R6", "wrap32", ea, 32'h0000_0010);
        // R4: sign-extended byte in wide form
        apply("R4", 3'd2, 2'd0, 32'h0000_0100, 32'h0, 2'd0, 32'h0000_0080, 2'd0,
              32'h0, 1, 0, 0, 3'd0);
        check("R4", "disp8 wide", ea, 32'h0000_0080);
        apply("R4", 3'd0, 2'd0, 32'h0, 32'h0, 2'd0, 32'h0000_8000, 2'd1,
              32'h0, 1, 0, 0, 3'd0);
        check("R4", "disp16 wide", ea, 32'hFFFF_8000);
    endtask

    task automatic t_prefix();
        apply("R2", 3'd0, 2'd0, 32'h0, 32'h0, 2'd0, 32'h0001_2345, 2'd2,
              32'h0, 0, 1, 0, 3'd0);
        check("R2", "pfx widens", {31'h0, addr32}, 32'h1);
        apply("R2", 3'd0, 2'd0, 32'h0, 32'h0, 2'd0, 32'h0001_2345, 2'd2,
              32'h0, 1, 1, 0, 3'd0);
        check("R2", "pfx narrows", ea, 32'h2345);
    endtask

    task automatic t_linear_override();
        apply("R7", 3'd0, 2'd0, 32'h0, 32'h0, 2'd0, 32'h0000_2000, 2'd2,
              32'hFFFF_F000, 1, 0, 0, 3'd0);
        check("R7", "lin wrap", lin_addr, 32'h0000_1000);
        apply("R9", 3'd2, 2'd1, 32'h0100, 32'h0, 2'd0, 32'h0, 2'd0,
              32'h0, 0, 0, 1, 3'd5);
        check("R9", "override", {29'h0, seg_sel}, 32'h5);
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        apply("R1", 3'd0, 2'd0, 32'h0, 32'h0, 2'd0, 32'h0000_7777, 2'd2,
              32'h0, 1, 0, 0, 3'd0);
        keep = ea;
        @(negedge clk);
        disp = 32'h1111_1111; mode = 3'd0;
        @(negedge clk);
        check("R1", "valid drops", {31'h0, out_valid}, 32'h0);
        check("R1", "ea held", ea, keep);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_direct();
        t_indirect();
        t_based_indexed();
        t_wrap16();
        t_wide();
        t_prefix();
        t_linear_override();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule